// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours (24-hour), day of month, weekday, month, two-digit year and a century bit. An internal prescaler divides the system clock, gated by an oscillator-rate enable, down to a one-second step. Each step runs a carry chain through all fields. Month lengths and leap years are handled.

Software reaches the fields through a flat register port. It has a write strobe with an address and data. It has a read address whose data comes back on the next cycle. It also has a hold input. While hold is high the counters stay still, so a multi-field read always sees one consistent time. A second that falls due during the hold is kept and applied once the hold ends. A clock-integrity flag sits in the top bit of the seconds register. A halt bit in a control register stops timekeeping.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59, and hours from 00 to 23. Each field wraps to 00 and passes a carry to the next field.
- R2: The weekday register (address 4) counts 0 to 6 and wraps to 0. It advances exactly when the day of month advances.
- R3: Bit 7 of the month register (address 5) is the century bit. It inverts when the year (address 6) goes from BCD 99 to 00, and it changes at no other time except a write to address 5.
- R4: While rd_lock is high, no time or calendar field changes except through a write.
- R5: Bit 7 of the seconds register (address 0) is the integrity flag. A cycle with low_volt high sets it. Only a write to address 0 clears it, and a low_volt pulse in the same cycle as that write wins. Writes to other addresses leave it unchanged.
- R6: While bit 0 of the control register (address 7) is 1, the prescaler is held at zero and no field advances.
- R7: A reset sets every register to zero, except the integrity flag, which becomes 1. Right after reset, address 0 reads 0x80.
- R8: One second that falls due while rd_lock is high is held. It is applied on the first cycle after rd_lock falls.
- R9: The day of month runs from 01 up to 28, 29, 30 or 31 and then returns to 01 with a month carry. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4, and 28 days otherwise. The month runs 01 to 12 and wraps to 01.
- R10: A write to addresses 0 to 6 takes effect at the clock edge that samples it. It discards any held second and restarts the prescaler. The next advance then comes exactly DIV_COUNT enabled cycles later.
- R11: rd_data shows the register at rd_addr one cycle after the address is presented. The address map is: 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year, 7 control. Bits that are not implemented read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator-rate enable counted by the prescaler |
| low_volt | input | 1 | Low-supply indication pulse, sets the integrity flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_lock | input | 1 | Holds the counters still during a software read |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |

## Verification
Some properties are checked by the assertions on every cycle. Fields do not move under a hold or a halt. The integrity flag is sticky. The century bit stays put unless the year is at 99 or software writes it. A seconds value of 59 can only stay or wrap to 00. The weekday stays inside 0 to 6.

Other behaviour only the bench scenarios can show. These are the exact cascades across month ends, leap Februaries and the year 99 rollover, and the release of a held second after a hold. They also include the timing of the first advance after a write, the read latency and the reset values.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] mon;
    logic [7:0] year;
    logic       cent;
  } cal_t;

  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HOUR = 3'd2;
  localparam logic [2:0] A_DAY  = 3'd3;
  localparam logic [2:0] A_WDAY = 3'd4;
  localparam logic [2:0] A_MON  = 3'd5;
  localparam logic [2:0] A_YEAR = 3'd6;
  localparam logic [2:0] A_CTL  = 3'd7;

  // Add one to a two-digit packed BCD value; 99 rolls to 00.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // Value 10*t+u is divisible by 4 when (2*t+u) mod 4 is zero.
  function automatic logic leap_year(input logic [7:0] y);
    logic [1:0] s;
    s = {y[4], 1'b0} + y[1:0];
    return (s == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic clear,
  output logic tick
);
  localparam int CNT_W = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = osc_en && !clear && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (osc_en) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_advance.sv
`timescale 1ns/1ps
module cal_advance
  import cal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0] last_day;

  always_comb begin
    last_day = month_len(cur.mon, cur.year);
    c_sec    = cur.sec >= 8'h59;
    c_min    = c_sec  && (cur.min  >= 8'h59);
    c_hour   = c_min  && (cur.hour >= 8'h23);
    c_day    = c_hour && (cur.day  >= last_day);
    c_mon    = c_day  && (cur.mon  >= 8'h12);
    c_year   = c_mon  && (cur.year >= 8'h99);

    nxt      = cur;
    nxt.sec  = c_sec ? 8'h00 : bcd_step(cur.sec);
    if (c_sec)  nxt.min  = c_min  ? 8'h00 : bcd_step(cur.min);
    if (c_min)  nxt.hour = c_hour ? 8'h00 : bcd_step(cur.hour);
    if (c_hour) begin
      nxt.day  = c_day ? 8'h01 : bcd_step(cur.day);
      nxt.wday = (cur.wday >= 8'd6) ? 8'd0 : cur.wday + 8'd1;
    end
    if (c_day)  nxt.mon  = c_mon ? 8'h01 : bcd_step(cur.mon);
    if (c_mon)  nxt.year = bcd_step(cur.year);
    if (c_year) nxt.cent = ~cur.cent;
  end
endmodule

// File: rtl/cal_regs.sv
`timescale 1ns/1ps
module cal_regs
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       lock,
  input  logic       low_volt,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  cal_t       nxt,
  output cal_t       st,
  output logic       vl_q,
  output logic       stop_q,
  output logic       time_wr
);
  logic pend_q;
  logic adv;

  assign time_wr = wr_en && (wr_addr != A_CTL);
  assign adv     = !time_wr && !stop_q && !lock && (tick || pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      stop_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (time_wr || stop_q) pend_q <= 1'b0;
      else if (lock)         pend_q <= pend_q | tick;
      else                   pend_q <= pend_q & tick;

      if (adv) st <= nxt;

      if (wr_en) begin
        case (wr_addr)
          A_SEC:  st.sec  <= {1'b0, wr_data[6:0]};
          A_MIN:  st.min  <= {1'b0, wr_data[6:0]};
          A_HOUR: st.hour <= {2'b0, wr_data[5:0]};
          A_DAY:  st.day  <= {2'b0, wr_data[5:0]};
          A_WDAY: st.wday <= {5'b0, wr_data[2:0]};
          A_MON: begin
            st.mon  <= {3'b0, wr_data[4:0]};
            st.cent <= wr_data[7];
          end
          A_YEAR: st.year <= wr_data;
          A_CTL:  stop_q  <= wr_data[0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               vl_q <= 1'b1;
    else if (low_volt)                     vl_q <= 1'b1;
    else if (wr_en && (wr_addr == A_SEC))  vl_q <= wr_data[7];
  end
endmodule

// File: rtl/cal_readmux.sv
`timescale 1ns/1ps
module cal_readmux
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cal_t       st,
  input  logic       vl_q,
  input  logic       stop_q,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else begin
      case (rd_addr)
        A_SEC:  rd_data <= st.sec | {vl_q, 7'b0};
        A_MIN:  rd_data <= st.min;
        A_HOUR: rd_data <= st.hour;
        A_DAY:  rd_data <= st.day;
        A_WDAY: rd_data <= st.wday;
        A_MON:  rd_data <= st.mon | {st.cent, 7'b0};
        A_YEAR: rd_data <= st.year;
        A_CTL:  rd_data <= {7'b0, stop_q};
      endcase
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       low_volt,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_lock,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  cal_t cal_st;
  cal_t cal_nxt;
  logic vl_q;
  logic stop_q;
  logic time_wr;
  logic sec_tick;

  cal_prescaler #(.DIV_COUNT(DIV_COUNT)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .osc_en (osc_en),
    .clear  (time_wr || stop_q),
    .tick   (sec_tick)
  );

  cal_advance u_adv (
    .cur (cal_st),
    .nxt (cal_nxt)
  );

  cal_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .lock     (rd_lock),
    .low_volt (low_volt),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .nxt      (cal_nxt),
    .st       (cal_st),
    .vl_q     (vl_q),
    .stop_q   (stop_q),
    .time_wr  (time_wr)
  );

  cal_readmux u_rd (
    .clk     (clk),
    .rst     (rst),
    .st      (cal_st),
    .vl_q    (vl_q),
    .stop_q  (stop_q),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/cal_checker.sv
`timescale 1ns/1ps
module cal_checker
  import cal_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       rd_lock,
  input logic       low_volt,
  input cal_t       st,
  input logic       vl,
  input logic       stop
);
  a_r4_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    (rd_lock && !wr_en) |=> $stable(st));

  a_r6_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_en) |=> $stable(st));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    low_volt |=> vl);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (vl && !(wr_en && wr_addr == A_SEC)) |=> vl);

  a_r3_century_hold: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_addr == A_MON) && st.year != 8'h99) |=> $stable(st.cent));

  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (st.sec == 8'h59 && !wr_en) |=> (st.sec == 8'h59 || st.sec == 8'h00));

  a_r2_wday_range: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_addr == A_WDAY) && st.wday <= 8'd6) |=> (st.wday <= 8'd6));
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_lock  (rd_lock),
  .low_volt (low_volt),
  .st       (cal_st),
  .vl       (vl_q),
  .stop     (stop_q)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b1;
  logic       low_volt = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_lock = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bcd_calendar #(.DIV_COUNT(DIV)) u0 (
    .clk(clk), .rst(rst), .osc_en(osc_en), .low_volt(low_volt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_lock(rd_lock), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct {int s; int m; int h; int d; int w; int mo; int y; int c;} tm_t;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t adv(input tm_t t);
    tm_t r = t;
    r.s++;
    if (r.s == 60) begin
      r.s = 0; r.m++;
      if (r.m == 60) begin
        r.m = 0; r.h++;
        if (r.h == 24) begin
          r.h = 0; r.w = (r.w + 1) % 7; r.d++;
          if (r.d > dim(t.mo, t.y)) begin
            r.d = 1; r.mo++;
            if (r.mo == 13) begin
              r.mo = 1; r.y++;
              if (r.y == 100) begin r.y = 0; r.c = 1 - r.c; end
            end
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] fld(input tm_t t, input int i);
    case (i)
      0: return bcd(t.s);
      1: return bcd(t.m);
      2: return bcd(t.h);
      3: return bcd(t.d);
      4: return 8'(t.w);
      5: return bcd(t.mo) | (t.c != 0 ? 8'h80 : 8'h00);
      default: return bcd(t.y);
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic set_time(input tm_t t);
    for (int i = 0; i < 7; i++) wr(3'(i), fld(t, i));
  endtask

  task automatic check_time(input tm_t t, input string req);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), v);
      chk(req, v, fld(t, i));
    end
  endtask

  task automatic run(input tm_t t, input int n, input string req);
    tm_t e = t;
    set_time(t);
    rd_lock = 1'b0;
    repeat (n * DIV) @(negedge clk);
    rd_lock = 1'b1;
    for (int k = 0; k < n; k++) e = adv(e);
    check_time(e, req);
  endtask

  function automatic tm_t mk(input int s, m, h, d, w, mo, y, c);
    tm_t r;
    r.s = s; r.m = m; r.h = h; r.d = d; r.w = w; r.mo = mo; r.y = y; r.c = c;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tm_t t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_lock = 1'b1;

    // R7 reset values, R11 address map
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R7", v, (i == 0) ? 8'h80 : 8'h00);
    end

    // R5 flag behaviour, R10 immediate write
    wr(0, 8'h05); rd(0, v); chk("R5 clear", v, 8'h05);
    low_volt = 1'b1; @(negedge clk); low_volt = 1'b0;
    rd(0, v); chk("R5 set", v & 8'h80, 8'h80);
    wr(1, 8'h10); rd(0, v); chk("R5 other write", v & 8'h80, 8'h80);
    low_volt = 1'b1; wr(0, 8'h00); low_volt = 1'b0;
    rd(0, v); chk("R5 set wins", v, 8'h80);

    // R1, R2, R9 directed rollovers
    run(mk(58, 7, 3, 5, 2, 6, 10, 0), 3, "R1 sec wrap");
    run(mk(59, 59, 23, 28, 6, 2, 23, 0), 1, "R9 feb 28 R2");
    run(mk(59, 59, 23, 28, 1, 2, 24, 0), 1, "R9 leap 29");
    run(mk(59, 59, 23, 29, 2, 2, 24, 0), 1, "R9 leap end");
    run(mk(59, 59, 23, 30, 3, 4, 5, 0), 1, "R9 april");
    run(mk(59, 59, 23, 31, 4, 12, 99, 0), 1, "R3 century");
    run(mk(59, 59, 23, 31, 4, 12, 99, 1), 1, "R3 century back");

    // R10 no advance before DIV cycles after a write
    t = mk(30, 20, 10, 15, 3, 8, 41, 0);
    set_time(t);
    rd_lock = 1'b0;
    repeat (DIV - 1) @(negedge clk);
    rd_lock = 1'b1;
    check_time(t, "R10 restart");

    // R4 freeze and R8 pending second
    t = mk(10, 0, 0, 1, 0, 1, 0, 0);
    set_time(t);
    rd_lock = 1'b0;
    repeat (DIV) @(negedge clk);
    rd_lock = 1'b1;
    t = adv(t);
    check_time(t, "R4 freeze");
    @(negedge clk);
    rd_lock = 1'b0;
    @(negedge clk);
    rd_lock = 1'b1;
    t = adv(t);
    check_time(t, "R8 pending");

    // R6 halt
    t = mk(45, 33, 12, 9, 5, 7, 77, 1);
    set_time(t);
    wr(7, 8'h01);
    rd_lock = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rd_lock = 1'b1;
    check_time(t, "R6 halted");
    rd(7, v); chk("R11 control", v, 8'h01);
    wr(7, 8'h00);
    rd_lock = 1'b0;
    repeat (DIV) @(negedge clk);
    rd_lock = 1'b1;
    check_time(adv(t), "R6 resume");

    // random scenarios
    for (int k = 0; k < 24; k++) begin
      t.y = $urandom_range(0, 99); t.c = $urandom_range(0, 1);
      t.mo = $urandom_range(1, 12); t.d = $urandom_range(1, dim(t.mo, t.y));
      t.w = $urandom_range(0, 6); t.h = $urandom_range(0, 23);
      t.m = $urandom_range(0, 59); t.s = $urandom_range(0, 59);
      if ($urandom_range(0, 1) == 1) begin
        t.s = 59; t.m = 59; t.h = 23;
        if ($urandom_range(0, 1) == 1) t.d = dim(t.mo, t.y);
      end
      run(t, $urandom_range(1, 4), "R1 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule